// File: doc/BRIEF.md
# Funnel-Shift Bit-Field Extractor

This unit pulls a contiguous bit field out of a pair of data words. The two 32-bit operands are placed side by side, the high operand on the left, to make one 64-bit word. That word is shifted right by a position, and the unit keeps a field whose length is the size code plus one. The field is returned right-justified, with zeros above it. One shifter and one mask serve every kind of extraction. These include single-bit tests, byte picks and rotates, which are obtained by passing the same word as both operands.

The position has two possible sources. In field mode it is taken directly from a 5-bit position input. In operand mode it is read from the low five bits of the high operand, which at the same time supplies the upper half of the shifted word.

Operand mode has two extra options. The first complements the position, so that bit numbering counts from the most significant bit. The second turns the position into a byte step: the position becomes eight times its value modulo four. The two options can be set together to step through bytes from the most significant end.

Each request sampled with its valid strobe produces a registered result and a matching valid strobe on the next clock edge.

Top module: `bfx_extract_unit`

## Requirements
- R1: With size code 31 in field mode, the result equals the low 32 bits of {op_hi, op_lo} shifted right by pos_field.
- R2: The extracted field is size_m1 + 1 bits wide: size code 0 keeps 1 bit and size code 31 keeps all 32 bits.
- R3: Every result bit at or above the field length is zero, whatever the operand bits are.
- R4: Position 0 with size code 31 returns op_lo unchanged. Position 31 returns op_lo bit 31 in result bit 0, with op_hi bits 30..0 in result bits 31..1.
- R5: When var_mode is 1, the position is op_hi[4:0], and the value on pos_field has no effect on the result.
- R6: In operand mode with msb_first set and byte_step clear, the position used is 31 minus op_hi[4:0]. For example, 30 gives a shift of 1.
- R7: In operand mode with byte_step set and msb_first clear, the position used is 8 × (op_hi[4:0] mod 4).
- R8: In operand mode with both msb_first and byte_step set, the position used is 8 × (3 − (op_hi[4:0] mod 4)).
- R9: When var_mode is 0, msb_first and byte_step have no effect on the result.
- R10: With op_hi equal to op_lo, size code 31 and field mode, the result is op_lo rotated right by pos_field.
- R11: A request with in_valid high appears on result one clock later, with out_valid high. When in_valid is low, out_valid falls on the next clock and result holds its last value. After reset, out_valid and result are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe; inputs are sampled when high |
| op_hi | input | 32 | Upper half of the joined word; also the position source in operand mode |
| op_lo | input | 32 | Lower half of the joined word |
| size_m1 | input | 5 | Field length minus one |
| pos_field | input | 5 | Right-shift position used in field mode |
| var_mode | input | 1 | 0: position from pos_field; 1: position from op_hi[4:0] |
| msb_first | input | 1 | Operand mode only: complement the position |
| byte_step | input | 1 | Operand mode only: scale the position to a byte step |
| out_valid | output | 1 | High for one cycle for each accepted request |
| result | output | 32 | Registered, right-justified, zero-extended field |

## Verification
In operand mode, the high operand's low bits choose the shift and the same bits also reach the output as data. Both roles act on one request in the same cycle. This case is provoked with high operands whose low five bits differ from pos_field and from the rest of the word. Position complementing and byte scaling can also fall on the same request when both flags are raised together. Each result is judged against a behavioural model that applies the flags in the stated order to a 64-bit word, and the model is compared with the outputs on every clock.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

   typedef enum logic {
      BFX_SRC_FIELD   = 1'b0,
      BFX_SRC_OPERAND = 1'b1
   } bfx_src_e;

   typedef struct packed {
      bfx_src_e src;
      logic     msb_first;
      logic     byte_step;
   } bfx_ctl_t;

endpackage

// File: rtl/bfx_pos_select.sv
module bfx_pos_select #(
   parameter int POS_W  = 5,
   parameter int BOFF_W = 3
) (
   input  logic [POS_W-1:0]  pos_field,
   input  logic [POS_W-1:0]  pos_operand,
   input  bfx_pkg::bfx_ctl_t ctl,
   output logic [POS_W-1:0]  pos_out
);
   logic             from_op;
   logic [POS_W-1:0] base;
   logic [POS_W-1:0] ordered;
   logic [POS_W-1:0] scaled;

   assign from_op = (ctl.src == bfx_pkg::BFX_SRC_OPERAND);
   assign base    = from_op ? pos_operand : pos_field;
   assign ordered = (from_op && ctl.msb_first) ? ~base : base;

   generate
      if (BOFF_W == 0) begin : g_no_scale
         assign scaled = ordered;
      end else begin : g_scale
         assign scaled = {ordered[POS_W-BOFF_W-1:0], {BOFF_W{1'b0}}};
      end
   endgenerate

   assign pos_out = (from_op && ctl.byte_step) ? scaled : ordered;
endmodule

// File: rtl/bfx_funnel.sv
module bfx_funnel #(
   parameter int WORD_W     = 32,
   parameter int POS_W      = 5,
   parameter int SHIFT_IMPL = 0
) (
   input  logic [2*WORD_W-2:0] joined,
   input  logic [POS_W-1:0]    shamt,
   output logic [WORD_W-1:0]   shifted
);
   generate
      if (SHIFT_IMPL == 0) begin : g_window
         for (genvar i = 0; i < WORD_W; i++) begin : g_bit
            logic [WORD_W-1:0] win;
            assign win        = joined[i+WORD_W-1:i];
            assign shifted[i] = win[shamt];
         end
      end else begin : g_operator
         assign shifted = WORD_W'(joined >> shamt);
      end
   endgenerate
endmodule

// File: rtl/bfx_field_mask.sv
module bfx_field_mask #(
   parameter int WORD_W = 32,
   parameter int POS_W  = 5
) (
   input  logic [POS_W-1:0]  size_m1,
   output logic [WORD_W-1:0] mask
);
   generate
      for (genvar i = 0; i < WORD_W; i++) begin : g_bit
         localparam logic [POS_W-1:0] IDX = POS_W'(i);
         assign mask[i] = (IDX <= size_m1);
      end
   endgenerate
endmodule

// File: rtl/bfx_extract_unit.sv
module bfx_extract_unit #(
   parameter int  WORD_W     = 32,
   parameter int  BYTE_W     = 8,
   parameter int  SHIFT_IMPL = 0,
   localparam int POS_W      = $clog2(WORD_W),
   localparam int BOFF_W     = $clog2(BYTE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] op_hi,
   input  logic [WORD_W-1:0] op_lo,
   input  logic [POS_W-1:0]  size_m1,
   input  logic [POS_W-1:0]  pos_field,
   input  logic              var_mode,
   input  logic              msb_first,
   input  logic              byte_step,
   output logic              out_valid,
   output logic [WORD_W-1:0] result
);
   generate
      if (WORD_W < 8 || (1 << POS_W) != WORD_W) begin : g_bad_word
         $error("bfx_extract_unit: WORD_W must be a power of two of at least 8");
      end
      if ((1 << BOFF_W) != BYTE_W || BOFF_W >= POS_W) begin : g_bad_byte
         $error("bfx_extract_unit: BYTE_W must be a power of two below WORD_W");
      end
      if (SHIFT_IMPL != 0 && SHIFT_IMPL != 1) begin : g_bad_impl
         $error("bfx_extract_unit: SHIFT_IMPL must be 0 or 1");
      end
   endgenerate

   bfx_pkg::bfx_ctl_t   ctl;
   logic [POS_W-1:0]    pos_eff;
   logic [2*WORD_W-2:0] joined;
   logic [WORD_W-1:0]   shifted;
   logic [WORD_W-1:0]   mask;

   assign ctl.src       = var_mode ? bfx_pkg::BFX_SRC_OPERAND : bfx_pkg::BFX_SRC_FIELD;
   assign ctl.msb_first = msb_first;
   assign ctl.byte_step = byte_step;

   // The top bit of op_hi can never reach the field: the shift stops at WORD_W-1.
   assign joined = {op_hi[WORD_W-2:0], op_lo};

   bfx_pos_select #(.POS_W(POS_W), .BOFF_W(BOFF_W)) u_pos (
      .pos_field  (pos_field),
      .pos_operand(op_hi[POS_W-1:0]),
      .ctl        (ctl),
      .pos_out    (pos_eff)
   );

   bfx_funnel #(.WORD_W(WORD_W), .POS_W(POS_W), .SHIFT_IMPL(SHIFT_IMPL)) u_funnel (
      .joined (joined),
      .shamt  (pos_eff),
      .shifted(shifted)
   );

   bfx_field_mask #(.WORD_W(WORD_W), .POS_W(POS_W)) u_mask (
      .size_m1(size_m1),
      .mask   (mask)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result <= shifted & mask;
         end
      end
   end
endmodule

// File: rtl/bfx_extract_checker.sv
module bfx_extract_checker #(
   parameter int WORD_W = 32,
   parameter int POS_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [WORD_W-1:0] op_hi,
   input logic [WORD_W-1:0] op_lo,
   input logic [POS_W-1:0]  size_m1,
   input logic [POS_W-1:0]  pos_field,
   input logic              var_mode,
   input logic              out_valid,
   input logic [WORD_W-1:0] result
);
   // R11: an accepted request is answered on the next edge
   a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R11: an idle cycle drops the strobe and keeps the data
   a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(result)));

   // R3: nothing is set above the field length
   a_r3_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((result >> ({1'b0, $past(size_m1)} + 1'b1)) == '0));

   // R4: position zero passes the low operand through
   a_r4_pos_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !var_mode && pos_field == '0 && size_m1 == '1)
      |=> (result == $past(op_lo)));

   // R10: equal operands give a rotate
   a_r10_rotate: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !var_mode && op_hi == op_lo && size_m1 == '1)
      |=> (result == (($past(op_lo) >> $past(pos_field)) |
                      ($past(op_lo) << (WORD_W - int'($past(pos_field)))))));
endmodule

bind bfx_extract_unit bfx_extract_checker #(.WORD_W(WORD_W), .POS_W(POS_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .op_hi    (op_hi),
   .op_lo    (op_lo),
   .size_m1  (size_m1),
   .pos_field(pos_field),
   .var_mode (var_mode),
   .out_valid(out_valid),
   .result   (result)
);

// File: tb/bfx_extract_unit_tb.sv
module bfx_extract_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] op_hi = '0;
   logic [31:0] op_lo = '0;
   logic [4:0]  size_m1 = '0;
   logic [4:0]  pos_field = '0;
   logic        var_mode = 1'b0;
   logic        msb_first = 1'b0;
   logic        byte_step = 1'b0;
   logic        out_valid;
   logic [31:0] result;

   int    total = 0;
   int    bad = 0;
   bit    finished = 1'b0;
   bit    exp_valid = 1'b0;
   logic [31:0] exp_result = '0;
   string exp_tag = "R11";

   always #4 clk = ~clk;

   bfx_extract_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .op_hi(op_hi), .op_lo(op_lo), .size_m1(size_m1), .pos_field(pos_field),
      .var_mode(var_mode), .msb_first(msb_first), .byte_step(byte_step),
      .out_valid(out_valid), .result(result)
   );

   function automatic logic [31:0] model(input logic [31:0] hi, input logic [31:0] lo,
                                         input int sz, input int pos,
                                         input bit vm, input bit rv, input bit by);
      int p;
      logic [63:0] j;
      logic [63:0] m;
      p = vm ? int'(hi[4:0]) : pos;
      if (vm && rv) p = 31 - p;
      if (vm && by) p = (p % 4) * 8;
      j = {hi, lo} >> p;
      m = (64'd1 << (sz + 1)) - 64'd1;
      return j[31:0] & m[31:0];
   endfunction

   task automatic compare();
      total++;
      if (out_valid !== exp_valid || result !== exp_result) begin
         bad++;
         $display("FAIL %s: valid=%b result=%h expected valid=%b result=%h",
                  exp_tag, out_valid, result, exp_valid, exp_result);
      end
   endtask

   task automatic step(input string tag, input bit v, input logic [31:0] hi,
                       input logic [31:0] lo, input int sz, input int pos,
                       input bit vm, input bit rv, input bit by);
      @(negedge clk);
      compare();
      in_valid  = v;
      op_hi     = hi;
      op_lo     = lo;
      size_m1   = 5'(sz);
      pos_field = 5'(pos);
      var_mode  = vm;
      msb_first = rv;
      byte_step = by;
      exp_valid = v;
      if (v) exp_result = model(hi, lo, sz, pos, vm, rv, by);
      exp_tag = tag;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      compare();                          // R11 reset state
      rst_n = 1'b1;
      step("R1",  1, 32'hDEADBEEF, 32'h12345678, 31, 8, 0, 0, 0);
      step("R1",  1, 32'h0F0F1234, 32'hCAFEF00D, 31, 17, 0, 0, 0);
      step("R2",  1, 32'hFFFFFFFF, 32'hA5A5A5A5, 0, 4, 0, 0, 0);
      step("R2",  1, 32'h13579BDF, 32'h2468ACE0, 7, 4, 0, 0, 0);
      step("R2",  1, 32'h13579BDF, 32'h2468ACE0, 15, 20, 0, 0, 0);
      step("R3",  1, 32'hFFFFFFFF, 32'hFFFFFFFF, 3, 10, 0, 0, 0);
      step("R4",  1, 32'h89ABCDEF, 32'h01234567, 31, 0, 0, 0, 0);
      step("R4",  1, 32'h00000003, 32'h80000000, 31, 31, 0, 0, 0);
      step("R5",  1, 32'hABCDE00D, 32'h55AA33CC, 31, 2, 1, 0, 0);
      step("R5",  1, 32'h7777771F, 32'h0BADF00D, 31, 0, 1, 0, 0);
      step("R6",  1, 32'h1234561E, 32'hF0E1D2C3, 31, 9, 1, 1, 0);
      step("R6",  1, 32'h00000000, 32'h80000001, 31, 3, 1, 1, 0);
      step("R7",  1, 32'hC0FFEE06, 32'h44332211, 7, 0, 1, 0, 1);
      step("R7",  1, 32'hC0FFEE1F, 32'h44332211, 15, 5, 1, 0, 1);
      step("R8",  1, 32'hA1B2C300, 32'h44332211, 7, 0, 1, 1, 1);
      step("R8",  1, 32'hA1B2C302, 32'h44332211, 7, 0, 1, 1, 1);
      step("R9",  1, 32'h0000001E, 32'h87654321, 31, 5, 0, 1, 1);
      step("R9",  1, 32'h0000001E, 32'h87654321, 11, 5, 0, 1, 0);
      step("R10", 1, 32'hA5F00F5A, 32'hA5F00F5A, 31, 4, 0, 0, 0);
      step("R10", 1, 32'h80000001, 32'h80000001, 31, 31, 0, 0, 0);
      step("R11", 0, 32'hFFFFFFFF, 32'hFFFFFFFF, 31, 0, 0, 0, 0);
      step("R11", 0, 32'h00000000, 32'h00000000, 0, 7, 1, 1, 1);
      for (int k = 0; k < 400; k++) begin
         step("R1", ($urandom % 4) != 0, $urandom, $urandom, $urandom % 32,
              $urandom % 32, $urandom % 2, $urandom % 2, $urandom % 2);
      end
      step("R11", 0, 32'h0, 32'h0, 0, 0, 0, 0, 0);
      step("R11", 0, 32'h0, 32'h0, 0, 0, 0, 0, 0);
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: run did not end, actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule